// File: doc/BRIEF.md
# Stepping Wiper Position Register

This block holds the 6-bit tap position of one digitally controlled resistor channel and drives a 64-way one-hot tap select from it. The position can be set in three ways. A recall strobe copies the stored power-up value into it. A host load strobe writes a value in one clock, and the same path serves both a direct write and a transfer from a stored setting. In step mode the position moves one tap per serial-clock pulse.

Step mode is open while `step_en_i` is high. The command decoder raises it after the increment/decrement instruction has been acknowledged and drops it at the stop condition. While the window is open, every rising edge of the synchronised serial clock moves the wiper one tap. The synchronised data line, sampled at that edge, gives the direction. Stepping stops at either end of the range and does not wrap.

Top module: `wiper_step_counter`

## Requirements
- R1: After reset, `pos_o` is 0 and only bit 0 of `tap_sel_o` is set.
- R2: `tap_sel_o` has exactly one bit set, at index `pos_o`. Bit 0 is the low terminal tap and bit 63 is the high terminal tap.
- R3: While `step_en_i` is high, a rising edge of `scl_i` with `sda_i` at 1 in that cycle raises `pos_o` by one on the next clock.
- R4: While `step_en_i` is high, a rising edge of `scl_i` with `sda_i` at 0 in that cycle lowers `pos_o` by one on the next clock.
- R5: A step up at position 63 leaves the position at 63.
- R6: A step down at position 0 leaves the position at 0.
- R7: While `step_en_i` is low, `scl_i` edges leave `pos_o` unchanged.
- R8: Only a low-to-high change of `scl_i` counts. Holding `scl_i` high for several clocks gives a single step, and a falling edge gives none.
- R9: `load_i` high for one clock sets `pos_o` to `load_val_i` on the next clock.
- R10: `recall_i` high sets `pos_o` to `recall_val_i` on the next clock and takes priority over a load in the same cycle.
- R11: When a load and a step fall in the same cycle, the loaded value is kept and the step is discarded.
- R12: With no strobe and no counted edge, `pos_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| recall_i | input | 1 | Power-up recall strobe |
| recall_val_i | input | 6 | Stored power-up position |
| load_i | input | 1 | Load strobe (direct write or transfer) |
| load_val_i | input | 6 | Value to load |
| step_en_i | input | 1 | Step-mode window |
| scl_i | input | 1 | Synchronised serial clock |
| sda_i | input | 1 | Synchronised serial data, gives the step direction |
| pos_o | output | 6 | Current wiper position |
| tap_sel_o | output | 64 | One-hot tap select |

## Verification
A load strobe and a counted serial-clock rising edge can arrive in the same clock. The bench provokes this by asserting `load_i` together with `step_en_i`, `scl_i` rising and `sda_i` high, at a position where a step alone would give a different result. The position one clock later must equal the loaded value and not that value plus or minus one. The bench also checks that the step is not replayed later while `scl_i` stays high. A recall that coincides with a load is judged the same way: the recalled value must appear.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  localparam int POS_W_DEF = 6;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_RECALL = 2'd1,
    ACT_LOAD   = 2'd2,
    ACT_STEP   = 2'd3
  } wiper_act_e;
endpackage

// File: rtl/wiper_step_detect.sv
module wiper_step_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_en_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic step_pulse_o,
  output logic step_up_o
);
  logic scl_q;

  // idle bus level is high, so an scl already high at reset exit is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scl_q <= 1'b1;
    else         scl_q <= scl_i;
  end

  assign step_pulse_o = step_en_i & scl_i & ~scl_q;
  assign step_up_o    = sda_i;

  assert_no_step_closed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_en_i |-> !step_pulse_o);
  assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_pulse_o |=> !step_pulse_o);
endmodule

// File: rtl/wiper_pos_reg.sv
module wiper_pos_reg
  import wiper_pkg::*;
#(
  parameter int POS_W = POS_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             recall_i,
  input  logic [POS_W-1:0] recall_val_i,
  input  logic             load_i,
  input  logic [POS_W-1:0] load_val_i,
  input  logic             step_pulse_i,
  input  logic             step_up_i,
  output logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] POS_MIN = '0;

  wiper_act_e       act;
  logic [POS_W-1:0] pos_q, pos_d;

  always_comb begin
    if (recall_i)          act = ACT_RECALL;
    else if (load_i)       act = ACT_LOAD;
    else if (step_pulse_i) act = ACT_STEP;
    else                   act = ACT_HOLD;
  end

  always_comb begin
    pos_d = pos_q;
    unique case (act)
      ACT_RECALL: pos_d = recall_val_i;
      ACT_LOAD:   pos_d = load_val_i;
      ACT_STEP: begin
        if (step_up_i && pos_q != POS_MAX)       pos_d = pos_q + 1'b1;
        else if (!step_up_i && pos_q != POS_MIN) pos_d = pos_q - 1'b1;
      end
      default:    pos_d = pos_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= pos_d;
  end

  assign pos_o = pos_q;

  assert_recall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_i |=> pos_q == $past(recall_val_i));
  assert_load_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !recall_i) |=> pos_q == $past(load_val_i));
  assert_step_up_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_pulse_i && step_up_i && !load_i && !recall_i && pos_q != POS_MAX)
      |=> pos_q == POS_W'($past(pos_q) + 1'b1));
  assert_step_down_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_pulse_i && !step_up_i && !load_i && !recall_i && pos_q != POS_MIN)
      |=> pos_q == POS_W'($past(pos_q) - 1'b1));
  assert_sat_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_pulse_i && step_up_i && !load_i && !recall_i && pos_q == POS_MAX)
      |=> pos_q == POS_MAX);
  assert_sat_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_pulse_i && !step_up_i && !load_i && !recall_i && pos_q == POS_MIN)
      |=> pos_q == POS_MIN);
  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_pulse_i && !load_i && !recall_i) |=> $stable(pos_q));
endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
  parameter int POS_W = 6,
  localparam int TAPS = 1 << POS_W
) (
  input  logic [POS_W-1:0] pos_i,
  output logic [TAPS-1:0]  tap_sel_o
);
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign tap_sel_o[t] = (pos_i == POS_W'(t));
  end
endmodule

// File: rtl/wiper_step_counter.sv
module wiper_step_counter
  import wiper_pkg::*;
#(
  parameter int POS_W = POS_W_DEF,
  localparam int TAPS = 1 << POS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             recall_i,
  input  logic [POS_W-1:0] recall_val_i,
  input  logic             load_i,
  input  logic [POS_W-1:0] load_val_i,
  input  logic             step_en_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic [POS_W-1:0] pos_o,
  output logic [TAPS-1:0]  tap_sel_o
);
  logic step_pulse, step_up;

  wiper_step_detect u_detect (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_en_i   (step_en_i),
    .scl_i       (scl_i),
    .sda_i       (sda_i),
    .step_pulse_o(step_pulse),
    .step_up_o   (step_up)
  );

  wiper_pos_reg #(.POS_W(POS_W)) u_pos (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .recall_i    (recall_i),
    .recall_val_i(recall_val_i),
    .load_i      (load_i),
    .load_val_i  (load_val_i),
    .step_pulse_i(step_pulse),
    .step_up_i   (step_up),
    .pos_o       (pos_o)
  );

  wiper_tap_decode #(.POS_W(POS_W)) u_dec (
    .pos_i    (pos_o),
    .tap_sel_o(tap_sel_o)
  );

  assert_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(tap_sel_o) == 1);
  assert_low_term_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_o == '0) |-> tap_sel_o[0]);
  assert_high_term_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_o == {POS_W{1'b1}}) |-> tap_sel_o[TAPS-1]);
endmodule

// File: tb/wiper_step_counter_tb.sv
`timescale 1ns/1ps
module wiper_step_counter_tb_top;
  localparam int W = 6;
  localparam int T = 1 << W;
  // ops: 0 load, 1 step up, 2 step down, 3 recall
  localparam int NV = 12;
  localparam int V_OP  [NV] = '{3, 1, 1, 2, 0, 2, 2, 0, 1, 2, 3, 1};
  localparam int V_VAL [NV] = '{33, 0, 0, 0, 5, 0, 0, 62, 0, 0, 7, 0};
  localparam int V_EXP [NV] = '{33, 34, 35, 34, 5, 4, 3, 62, 63, 62, 7, 8};

  logic clk = 0, rst_ni = 0;
  logic recall_i = 0, load_i = 0, step_en_i = 0, scl_i = 0, sda_i = 0;
  logic [W-1:0] recall_val_i = '0, load_val_i = '0;
  logic [W-1:0] pos_o;
  logic [T-1:0] tap_sel_o;
  int errors = 0, checks = 0, cycles = 0;

  always #2.5 clk = ~clk;

  wiper_step_counter dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .recall_i(recall_i), .recall_val_i(recall_val_i),
    .load_i(load_i), .load_val_i(load_val_i), .step_en_i(step_en_i),
    .scl_i(scl_i), .sda_i(sda_i), .pos_o(pos_o), .tap_sel_o(tap_sel_o));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input int exp);
    logic [T-1:0] exp_sel;
    exp_sel = T'(1) << exp;
    checks++;
    if (pos_o !== W'(exp) || tap_sel_o !== exp_sel) begin
      errors++;
      $display("FAIL %s: actual pos=%0d sel=%h expected pos=%0d sel=%h",
               req, pos_o, tap_sel_o, exp, exp_sel);
    end
  endtask

  task automatic do_load(input int v);
    @(negedge clk) load_i = 1; load_val_i = W'(v);
    @(negedge clk) load_i = 0;
  endtask

  task automatic do_recall(input int v);
    @(negedge clk) recall_i = 1; recall_val_i = W'(v);
    @(negedge clk) recall_i = 0;
  endtask

  task automatic do_pulse(input logic up);
    @(negedge clk) sda_i = up; scl_i = 1;
    @(negedge clk) scl_i = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 0);
    rst_ni = 1;
    @(negedge clk);
    step_en_i = 1;

    // table walk: R3 R4 R9 R10
    for (int i = 0; i < NV; i++) begin
      case (V_OP[i])
        0: do_load(V_VAL[i]);
        1: do_pulse(1'b1);
        2: do_pulse(1'b0);
        default: do_recall(V_VAL[i]);
      endcase
      check($sformatf("R2/R3/R4/R9/R10 vector %0d", i), V_EXP[i]);
    end

    // R5 saturation high, R6 saturation low
    do_load(63); do_pulse(1'b1); check("R5 sat high", 63);
    do_load(0);  do_pulse(1'b0); check("R6 sat low", 0);

    // R7 window closed
    do_load(20);
    step_en_i = 0;
    do_pulse(1'b1); do_pulse(1'b0);
    check("R7 closed window", 20);

    // R8 held high counts once; falling edge counts nothing
    step_en_i = 1;
    @(negedge clk) sda_i = 1; scl_i = 1;
    repeat (4) @(negedge clk);
    check("R8 held high", 21);
    scl_i = 0;
    @(negedge clk);
    check("R8 falling edge", 21);

    // R11 load against coincident step
    @(negedge clk) load_i = 1; load_val_i = 10; sda_i = 1; scl_i = 1;
    @(negedge clk) load_i = 0;
    check("R11 load wins", 10);
    @(negedge clk) scl_i = 0;
    @(negedge clk);
    check("R11 no late step", 10);

    // R10 recall over load
    @(negedge clk) recall_i = 1; recall_val_i = 44; load_i = 1; load_val_i = 3;
    @(negedge clk) recall_i = 0; load_i = 0;
    check("R10 recall over load", 44);

    // R12 idle hold
    repeat (5) @(negedge clk);
    check("R12 idle hold", 44);

    // R1 asynchronous reset mid-run
    @(negedge clk) rst_ni = 0;
    #1 check("R1 async reset", 0);
    @(negedge clk) rst_ni = 1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule